// File: doc/BRIEF.md
# Sequential-Access I2C Configuration Target

This block is the configuration port of a multi-lane signal conditioning device. It listens on a two-wire I2C bus as a target only, using 7-bit addressing at standard-mode rate. It oversamples SCL and SDA with the system clock. Two upper address bits are tied high, two middle bits are tied low, and three bits come from strap pins, so up to eight such devices can share one bus.

The target has no register pointer. Every transfer begins at register 0 and moves one byte upward after each byte. In a write, the first data byte goes straight into register 0. In a read, register 0 is returned first.

The bank holds twelve bytes:

- Bytes 0 and 1 are status. They are captured from input ports when a read address is acknowledged.
- Bytes 2 to 9 are control bytes. They drive a flat output vector.
- Bytes 10 and 11 are reserved.

The target pulls SDA low only while SCL is low, and it never drives SCL.

Top module: `lane_cfg_i2c`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal {1, 1, strapAddr[2], 0, 0, strapAddr[1], strapAddr[0]}, MSB first, by holding SDA low during the ninth clock. Any other address is left unacknowledged, and SDA stays released until the next START.
- R2: The eighth bit of the address byte selects the direction: 1 for read, 0 for write.
- R3: In a write, the first data byte after the address is stored at register 0 and each later byte at the next register. Every byte whose index is 11 or lower is acknowledged.
- R4: Register 2+k (k = 0..7) appears on cfgBytes[8k+7:8k]. The control outputs change only when an acknowledged data byte is written to them.
- R5: Writes to registers 0, 1, 10 and 11 are acknowledged but change nothing. Reads of registers 10 and 11 return 0x00.
- R6: In a read, data starts at register 0, MSB first, and moves to the next register each time the master acknowledges. A master NACK ends the read and SDA is released.
- R7: Registers 0 and 1 return the values of sigDetect and rxDetect captured when the read address is acknowledged. Later changes on those inputs do not affect the values returned.
- R8: Once the index passes 11, reads return 0xFF and writes are left unacknowledged without storing anything.
- R9: A STOP ends a transfer and keeps every byte already written. A repeated START resets the register index to 0.
- R10: The SDA pull-down changes only while SCL is low.
- R11: While rstN is low, every control output is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Level on the SCL wire |
| sdaIn | input | 1 | Level on the SDA wire |
| strapAddr | input | 3 | Strap pins for address bits 4, 1 and 0 |
| sigDetect | input | 8 | Per-lane signal-present status, read as register 0 |
| rxDetect | input | 8 | Per-lane receiver-load status, read as register 1 |
| sdaLow | output | 1 | 1 pulls SDA low; 0 releases it |
| cfgBytes | output | 64 | Control registers 2 to 9, one byte each |

## Verification
The bus inputs pass through two synchronizer flops and one edge-detect flop. Because of this, every action of the target lands about three system clocks after the SCL edge that causes it. An acknowledge or a data bit appears shortly after SCL falls. A control byte is committed after the falling edge that ends its eighth bit. The bus-master model waits a full quarter bit period after each SCL change before it samples SDA or updates its own register model. On every clock where SCL is high, the bench compares cfgBytes with that model. No commit can occur in that phase, so the comparison never lands in the short window where the target has committed but the model has not.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  localparam int BYTE_W      = 8;
  localparam int REG_COUNT   = 12;
  localparam int CTRL_FIRST  = 2;
  localparam int CTRL_COUNT  = 8;
  localparam int IDX_W       = $clog2(REG_COUNT + 1);
  localparam logic [6:0] ADDR_FIXED = 7'b110_0000;
  localparam logic [BYTE_W-1:0] PAST_END = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_AHOLD, ST_WR, ST_WACK, ST_WHOLD,
    ST_RD, ST_RREL, ST_RACK, ST_RLOAD, ST_SKIP
  } busState_e;

  typedef struct packed {
    logic              wrEn;
    logic              snapEn;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] wrData;
  } regStrobe_t;
endpackage

// File: rtl/lcfg_sync.sv
module lcfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  // Bus lines idle high, so the chain also resets high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], din};
  end

  assign dout = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/lcfg_ctrl.sv
module lcfg_ctrl import lcfg_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rdByte,
  output regStrobe_t        strobe,
  output logic              sdaLow
);
  busState_e         state;
  logic              sclP, sdaP;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [IDX_W-1:0]  idx;
  logic              isRead;
  logic              drvLow;

  logic sclRise, sclFall, startSeen, stopSeen, pastEnd, addrHit;
  logic [6:0] myAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startSeen = sclS & sclP & sdaP & ~sdaS;
  assign stopSeen  = sclS & sclP & ~sdaP & sdaS;
  // R1: two fixed-high bits, two fixed-low bits, three strap bits
  assign myAddr    = ADDR_FIXED | {2'b00, strap[2], 2'b00, strap[1:0]};
  assign addrHit   = (shiftReg[7:1] == myAddr);
  assign pastEnd   = (idx >= IDX_W'(REG_COUNT));   // R8

  always_comb begin
    strobe        = '0;
    strobe.idx    = idx;
    strobe.wrData = shiftReg;
    strobe.wrEn   = (state == ST_WACK) && sclFall && !pastEnd;
    // R7: status capture when a read address is acknowledged (R2: bit 0 = 1 means read)
    strobe.snapEn = (state == ST_AACK) && sclFall && addrHit && shiftReg[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      idx      <= '0;
      isRead   <= 1'b0;
      drvLow   <= 1'b0;
    end else if (startSeen) begin
      state  <= ST_ADDR;      // R9: every START, repeated or not, rewinds to 0
      bitCnt <= '0;
      idx    <= '0;
      drvLow <= 1'b0;
    end else if (stopSeen) begin
      state  <= ST_IDLE;
      drvLow <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: if (sclRise) begin
          shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
          bitCnt   <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) state <= (state == ST_ADDR) ? ST_AACK : ST_WACK;
        end
        ST_AACK: if (sclFall) begin
          if (addrHit) begin
            drvLow <= 1'b1;
            isRead <= shiftReg[0];
            state  <= ST_AHOLD;
          end else begin
            state  <= ST_SKIP;
          end
        end
        ST_AHOLD: if (sclFall) begin
          if (isRead) begin
            shiftReg <= rdByte;
            drvLow   <= ~rdByte[BYTE_W-1];
            state    <= ST_RD;
          end else begin
            drvLow <= 1'b0;
            state  <= ST_WR;
          end
        end
        ST_WACK: if (sclFall) begin
          drvLow <= ~pastEnd;
          state  <= ST_WHOLD;
        end
        ST_WHOLD: if (sclFall) begin
          drvLow <= 1'b0;
          if (!pastEnd) idx <= idx + IDX_W'(1);
          state  <= ST_WR;
        end
        ST_RD: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) state <= ST_RREL;
          end else if (sclFall) begin
            shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
            drvLow   <= ~shiftReg[BYTE_W-2];
          end
        end
        ST_RREL: if (sclFall) begin
          drvLow <= 1'b0;
          state  <= ST_RACK;
        end
        ST_RACK: if (sclRise) begin
          if (sdaS) begin
            state <= ST_SKIP;          // R6: master NACK ends the read
          end else begin
            if (!pastEnd) idx <= idx + IDX_W'(1);
            state <= ST_RLOAD;
          end
        end
        ST_RLOAD: if (sclFall) begin
          shiftReg <= rdByte;
          drvLow   <= ~rdByte[BYTE_W-1];
          state    <= ST_RD;
        end
        default: ;
      endcase
    end
  end

  assign sdaLow = drvLow;
endmodule

// File: rtl/lcfg_regs.sv
module lcfg_regs import lcfg_pkg::*; (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobe_t                   strobe,
  input  logic [BYTE_W-1:0]            sigIn,
  input  logic [BYTE_W-1:0]            rxIn,
  output logic [BYTE_W-1:0]            rdByte,
  output logic [CTRL_COUNT*BYTE_W-1:0] ctrlFlat
);
  logic [BYTE_W-1:0] snapSig, snapRx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapSig <= '0;
      snapRx  <= '0;
    end else if (strobe.snapEn) begin
      snapSig <= sigIn;
      snapRx  <= rxIn;
    end
  end

  // R4, R11: one byte register per control slot
  for (genvar g = 0; g < CTRL_COUNT; g++) begin : g_ctrl
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (strobe.wrEn && strobe.idx == IDX_W'(CTRL_FIRST + g)) q <= strobe.wrData;
    end
    assign ctrlFlat[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rdByte = PAST_END;                                   // R8
    if (strobe.idx < IDX_W'(REG_COUNT)) rdByte = '0;     // R5 reserved bytes
    for (int k = 0; k < CTRL_COUNT; k++)
      if (strobe.idx == IDX_W'(CTRL_FIRST + k)) rdByte = ctrlFlat[k*BYTE_W +: BYTE_W];
    if (strobe.idx == IDX_W'(0)) rdByte = snapSig;       // R7
    if (strobe.idx == IDX_W'(1)) rdByte = snapRx;
  end
endmodule

// File: rtl/lane_cfg_i2c.sv
module lane_cfg_i2c import lcfg_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sclIn,
  input  logic                         sdaIn,
  input  logic [2:0]                   strapAddr,
  input  logic [BYTE_W-1:0]            sigDetect,
  input  logic [BYTE_W-1:0]            rxDetect,
  output logic                         sdaLow,
  output logic [CTRL_COUNT*BYTE_W-1:0] cfgBytes
);
  logic [1:0]        busSync;
  regStrobe_t        strobe;
  logic [BYTE_W-1:0] rdByte;

  lcfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sclIn, sdaIn}),
    .dout (busSync)
  );

  lcfg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclS   (busSync[1]),
    .sdaS   (busSync[0]),
    .strap  (strapAddr),
    .rdByte (rdByte),
    .strobe (strobe),
    .sdaLow (sdaLow)
  );

  lcfg_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sigIn    (sigDetect),
    .rxIn     (rxDetect),
    .rdByte   (rdByte),
    .ctrlFlat (cfgBytes)
  );
endmodule

// File: rtl/lcfg_chk.sv
module lcfg_chk import lcfg_pkg::*; (
  input logic                         clk,
  input logic                         rstN,
  input logic                         sclIn,
  input logic                         sdaLow,
  input logic [CTRL_COUNT*BYTE_W-1:0] cfgBytes,
  input regStrobe_t                   strobe
);
  a_r10_drive_while_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow != $past(sdaLow)) |-> !sclIn);

  a_r4_change_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBytes != $past(cfgBytes)) |-> $past(strobe.wrEn));

  a_r5_nonctrl_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.wrEn) && (($past(strobe.idx) < IDX_W'(CTRL_FIRST)) ||
     ($past(strobe.idx) >= IDX_W'(CTRL_FIRST + CTRL_COUNT)))) |-> $stable(cfgBytes));

  a_r8_past_end_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.idx == IDX_W'(REG_COUNT)) |=> $stable(cfgBytes));
endmodule

bind lane_cfg_i2c lcfg_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaLow   (sdaLow),
  .cfgBytes (cfgBytes),
  .strobe   (strobe)
);

// File: tb/sim_lane_cfg_i2c.sv
module sim_lane_cfg_i2c;
  localparam int CLK_HALF = 2500;   // 5 ns period at the default 1 ps unit: 200 MHz
  localparam int QTR      = 12;     // system clocks per quarter bit
  localparam int WDOG     = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] strap = 3'b000;
  logic [7:0] sig = 8'h00;
  logic [7:0] rx = 8'h00;
  logic sdaLow;
  logic [63:0] cfg;
  wire sdaLine;
  assign sdaLine = sdaM & ~sdaLow;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [12];
  int bIdx = 0;
  bit addressed = 1'b0;
  bit cmpOn = 1'b0;
  logic [7:0] snapSig = 8'h00;
  logic [7:0] snapRx = 8'h00;

  always #CLK_HALF clk = ~clk;

  lane_cfg_i2c u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .strapAddr(strap),
    .sigDetect(sig), .rxDetect(rx), .sdaLow(sdaLow), .cfgBytes(cfg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mdlFlat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = mdl[2 + k];
    return f;
  endfunction

  function automatic logic [6:0] devAddr(input logic [2:0] s);
    return {2'b11, s[2], 2'b00, s[1:0]};
  endfunction

  function automatic logic [7:0] expRead(input int i);
    if (i == 0) return snapSig;
    if (i == 1) return snapRx;
    if (i >= 2 && i <= 9) return mdl[i];
    if (i <= 11) return 8'h00;
    return 8'hFF;
  endfunction

  // R4: control outputs match the model whenever SCL is high
  always @(negedge clk)
    if (cmpOn && rstN && sclLine) chk("R4", cfg, mdlFlat());

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic sendStart();
    sdaM = 1'b1; q(); sclLine = 1'b1; q(); sdaM = 1'b0; q(); sclLine = 1'b0; q();
  endtask

  task automatic sendStop();
    sdaM = 1'b0; q(); sclLine = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic bitXfer(input logic b, output logic got);
    sdaM = b; q(); sclLine = 1'b1; q(); got = sdaLine; q(); sclLine = 1'b0; q();
  endtask

  task automatic sendAddr(input logic [6:0] a, input logic rd, input bit expAck, input string req);
    logic got;
    logic [7:0] v;
    v = {a, rd};
    for (int b = 7; b >= 0; b--) bitXfer(v[b], got);
    if (rd && expAck) begin snapSig = sig; snapRx = rx; end
    bitXfer(1'b1, got);
    chk(req, 64'(got), 64'(!expAck));
    addressed = expAck;
    bIdx = 0;
  endtask

  task automatic writeData(input logic [7:0] d);
    logic got;
    bit expAck;
    string req;
    for (int b = 7; b >= 0; b--) bitXfer(d[b], got);
    expAck = addressed && bIdx < 12;
    if (addressed && bIdx >= 2 && bIdx <= 9) mdl[bIdx] = d;
    if (!addressed) req = "R1";
    else if (bIdx >= 12) req = "R8";
    else if (bIdx < 2 || bIdx > 9) req = "R5";
    else req = "R3";
    bitXfer(1'b1, got);
    chk(req, 64'(got), 64'(!expAck));
    bIdx++;
  endtask

  task automatic readData(input bit ackIt);
    logic got;
    logic [7:0] d;
    logic [7:0] e;
    string req;
    for (int b = 7; b >= 0; b--) begin bitXfer(1'b1, got); d[b] = got; end
    e = addressed ? expRead(bIdx) : 8'hFF;
    if (!addressed) req = "R1";
    else if (bIdx < 2) req = "R7";
    else if (bIdx <= 9) req = "R6";
    else if (bIdx <= 11) req = "R5";
    else req = "R8";
    bitXfer(!ackIt, got);
    chk(req, 64'(d), 64'(e));
    bIdx++;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) mdl[i] = 8'h00;
    repeat (8) @(negedge clk);
    chk("R11", cfg, 64'h0);
    chk("R11", 64'(sdaLow), 64'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    cmpOn = 1'b1;

    // R3 R5 R8: fill all twelve registers, then one byte past the end
    sendStart();
    sendAddr(devAddr(strap), 1'b0, 1'b1, "R1");
    for (int i = 0; i < 13; i++) writeData(8'h10 + 8'(i * 17));
    sendStop();
    chk("R4", cfg, mdlFlat());

    // R2 R6 R7 R8: read everything; status changes after the address must not show
    sig = 8'hA5; rx = 8'h3C;
    sendStart();
    sendAddr(devAddr(strap), 1'b1, 1'b1, "R2");
    sig = 8'h5A; rx = 8'hC3;
    for (int i = 0; i < 14; i++) readData(i < 13);
    chk("R6", 64'(sdaLow), 64'h0);
    sendStop();

    // R9: early STOP after the third byte
    sendStart();
    sendAddr(devAddr(strap), 1'b0, 1'b1, "R9");
    writeData(8'h00); writeData(8'h00); writeData(8'h77);
    sendStop();
    chk("R9", cfg, mdlFlat());

    // R9: repeated START rewinds the index to register 0
    sendStart();
    sendAddr(devAddr(strap), 1'b0, 1'b1, "R9");
    writeData(8'h01); writeData(8'h02); writeData(8'h11); writeData(8'h22);
    sendStart();
    sendAddr(devAddr(strap), 1'b0, 1'b1, "R9");
    writeData(8'h03); writeData(8'h04); writeData(8'h99);
    sendStop();
    chk("R9", 64'(cfg[7:0]), 64'h99);
    chk("R9", 64'(cfg[15:8]), 64'h22);

    // R2 R9: write then repeated START into a read returns register 0
    sendStart();
    sendAddr(devAddr(strap), 1'b0, 1'b1, "R2");
    writeData(8'h55);
    sendStart();
    sendAddr(devAddr(strap), 1'b1, 1'b1, "R2");
    readData(1'b0);
    sendStop();

    // R1: foreign addresses are ignored, line stays released
    sendStart();
    sendAddr(devAddr(strap) ^ 7'h20, 1'b0, 1'b0, "R1");
    writeData(8'h33);
    sendStop();
    sendStart();
    sendAddr(devAddr(strap) ^ 7'h40, 1'b1, 1'b0, "R1");
    readData(1'b0);
    sendStop();
    chk("R1", cfg, mdlFlat());

    // R1: every strap combination
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      repeat (4) @(negedge clk);
      sendStart();
      sendAddr(devAddr(strap), 1'b0, 1'b1, "R1");
      writeData(8'h00); writeData(8'h00); writeData(8'h40 | 8'(s));
      sendStop();
      sendStart();
      sendAddr(devAddr(strap ^ 3'b101), 1'b0, 1'b0, "R1");
      sendStop();
      chk("R1", 64'(cfg[7:0]), 64'(8'h40 | 8'(s)));
    end

    cmpOn = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule